// File: doc/BRIEF.md
# Serial Framed Packet Receiver

This block listens on one asynchronous serial line and turns it into short command frames. The line is first brought into the clock domain, then split into 8N1 characters (one start bit, eight data bits least significant first, one stop bit) by a bit-timing counter that samples each bit at its centre. The default rate is 115200 baud. A byte-level parser then looks for a header made of two 0x7E bytes. After the header it expects a kind byte, which must be 0x01 (setting frame) or 0x88 (report frame). The byte after that is the argument.

When a frame completes, the block raises `frame_valid` for one clock and presents the kind and the argument, which stay unchanged until the next good frame. It raises `frame_error` for one clock whenever a frame that has started is abandoned. That happens on a bad second header byte or an unknown kind byte, and the parser then goes back to looking for a header. Characters with a bad stop bit are thrown away before they reach the parser.

Top module: `frx_packet_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), all state clears: both pulse outputs are 0, `frame_flag` and `frame_param` are 0x00, and the parser is looking for a header.
- R2: Characters are received as 8N1 at CLK_FREQ_HZ/BAUD_RATE clocks per bit, with data bits least significant first and each bit sampled at its centre. A frame 7E 7E 01 B2 reports kind 0x01 and argument 0xB2.
- R3: `frame_valid` is high for exactly one clock per good frame. `frame_flag` and `frame_param` change only in that clock and hold their values through later error pulses.
- R4: The kind byte 0x88 is accepted as well as 0x01. These are the only two accepted kinds, so `frame_flag` is always 0x01 or 0x88 while `frame_valid` is high.
- R5: Once a first 0x7E has been seen, any other value in the second header position gives a one-clock `frame_error` and a return to header search. Bytes that follow are not taken as a kind.
- R6: A kind byte other than 0x01 or 0x88 after a complete header, including 0x7E, gives a one-clock `frame_error` and a return to header search. `frame_valid` and `frame_error` are never high in the same clock.
- R7: Any byte value, including 0x7E, is accepted as the argument of a frame.
- R8: A character whose stop bit is sampled low is discarded. It produces no pulse and does not move the parser, so 7E, a bad-stop 7E, then 7E 01 C3 yields one good frame (0x01, 0xC3).
- R9: A low pulse on the line shorter than half a bit time does not start a character. The line must still be low at the centre of the start bit.
- R10: While searching for a header, bytes other than 0x7E are ignored and produce neither output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| frame_valid | output | 1 | One-clock pulse when a frame completes |
| frame_flag | output | 8 | Kind byte of the last good frame |
| frame_param | output | 8 | Argument byte of the last good frame |
| frame_error | output | 1 | One-clock pulse when a started frame is dropped |

## Verification
The hold assertion on the output bytes compares each value with the one from the previous clock. It therefore assumes reset is held for at least two clocks, so that the previous sample is already a cleared value, and the bench holds reset for five. The pulse-width and exclusivity checks assume that characters arrive at least one bit time apart, which is always true on a real 8N1 line. The bench drives every character for exactly the nominal number of clocks per bit and leaves two idle bit times after each stop bit. The one exception is the deliberate sub-half-bit glitch.

// File: rtl/frx_pkg.sv
// Shared constants, state types and helpers for the framed serial receiver.
// Assumes 8-bit characters; header and kind codes are fixed by the protocol.
package frx_pkg;
    localparam int          BYTE_W       = 8;
    localparam logic [7:0]  HDR_BYTE     = 8'h7E;
    localparam logic [7:0]  KIND_SETTING = 8'h01;
    localparam logic [7:0]  KIND_REPORT  = 8'h88;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    typedef enum logic [1:0] {P_HUNT, P_HDR2, P_KIND, P_ARG} parse_state_t;

    // True for the two kind codes the parser accepts.
    function automatic logic kind_known(input logic [7:0] b);
        return (b == KIND_SETTING) || (b == KIND_REPORT);
    endfunction
endpackage

// File: rtl/frx_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2; RESET_VAL is the idle level of the input.
module frx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/frx_char_rx.sv
// Character receiver: finds a falling edge, confirms the start bit at its
// centre, samples DATA_BITS bits at their centres (LSB first) and checks the
// stop bit. Good characters give a one-clock byte_vld; a low stop bit gives
// a one-clock char_err and the byte is dropped.
// Assumes line is already synchronous and CLKS_PER_BIT >= 4.
module frx_char_rx #(
    parameter int CLKS_PER_BIT = 434,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line,
    output logic                 byte_vld,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 char_err
);
    import frx_pkg::*;

    localparam int CNT_W   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int BIT_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int HALF_M1 = CLKS_PER_BIT / 2 - 1;
    localparam int FULL_M1 = CLKS_PER_BIT - 1;

    rx_state_t            state;
    logic [CNT_W-1:0]     cnt;
    logic [BIT_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 line_q;

    // Bit-timing state machine: edge detect, centre sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            line_q   <= 1'b1;
            byte_vld <= 1'b0;
            char_err <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            char_err <= 1'b0;
            line_q   <= line;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (line_q && !line) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == CNT_W'(HALF_M1)) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CNT_W'(FULL_M1)) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[DATA_BITS-1:1]};
                        if (bit_idx == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_W'(FULL_M1)) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                        if (line) byte_vld <= 1'b1;
                        else      char_err <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign byte_data = shreg;

    // R2
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
    // R8
    stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && char_err));
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FULL_M1));
    // R9
    glitch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(state) == RX_STOP);
endmodule

// File: rtl/frx_frame_parser.sv
// Byte-level frame parser: searches for two header bytes, checks the kind
// byte, captures the argument and reports good or dropped frames.
// Assumes byte_vld pulses are at least two clocks apart.
module frx_frame_parser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    output logic       frame_valid,
    output logic [7:0] frame_flag,
    output logic [7:0] frame_param,
    output logic       frame_error
);
    import frx_pkg::*;

    parse_state_t st;
    logic [7:0]   pend_kind;

    // Frame state machine; outputs update only when a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= P_HUNT;
            pend_kind   <= '0;
            frame_valid <= 1'b0;
            frame_error <= 1'b0;
            frame_flag  <= '0;
            frame_param <= '0;
        end else begin
            frame_valid <= 1'b0;
            frame_error <= 1'b0;
            if (byte_vld) begin
                case (st)
                    P_HUNT: if (byte_data == HDR_BYTE) st <= P_HDR2;
                    P_HDR2: begin
                        if (byte_data == HDR_BYTE) begin
                            st <= P_KIND;
                        end else begin
                            frame_error <= 1'b1;
                            st          <= P_HUNT;
                        end
                    end
                    P_KIND: begin
                        if (kind_known(byte_data)) begin
                            pend_kind <= byte_data;
                            st        <= P_ARG;
                        end else begin
                            frame_error <= 1'b1;
                            st          <= P_HUNT;
                        end
                    end
                    P_ARG: begin
                        frame_flag  <= pend_kind;
                        frame_param <= byte_data;
                        frame_valid <= 1'b1;
                        st          <= P_HUNT;
                    end
                    default: st <= P_HUNT;
                endcase
            end
        end
    end

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(frame_flag) && $stable(frame_param)));
    // R4
    kind_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> kind_known(frame_flag));
    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && frame_error));
    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |=> !frame_error);
endmodule

// File: rtl/frx_packet_rx.sv
// Top of the framed serial receiver: synchronizer, character receiver and
// frame parser in a chain. Assumes CLK_FREQ_HZ / BAUD_RATE >= 4.
module frx_packet_rx #(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int BAUD_RATE   = 115_200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       serial_in,
    output logic       frame_valid,
    output logic [7:0] frame_flag,
    output logic [7:0] frame_param,
    output logic       frame_error
);
    import frx_pkg::*;

    localparam int CLKS_PER_BIT = CLK_FREQ_HZ / BAUD_RATE;

    logic              line_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              char_err;

    frx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(serial_in), .q(line_s));

    frx_char_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(BYTE_W)) i_char (
        .clk(clk), .rst_n(rst_n), .line(line_s),
        .byte_vld(byte_vld), .byte_data(byte_data), .char_err(char_err));

    frx_frame_parser i_parse (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_valid(frame_valid), .frame_flag(frame_flag),
        .frame_param(frame_param), .frame_error(frame_error));

    // R8
    dropped_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_err |=> !frame_valid && !frame_error);
endmodule

// File: tb/test_frx_packet_rx.sv
module test_frx_packet_rx;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_600_000;
    localparam int BAUD       = 100_000;
    localparam int CPB        = CLK_HZ / BAUD;

    typedef struct {
        bit         is_err;
        logic [7:0] flag;
        logic [7:0] param;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serial_in = 1'b1;
    logic frame_valid, frame_error;
    logic [7:0] frame_flag, frame_param;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    logic [7:0] last_flag = 8'h00;
    logic [7:0] last_param = 8'h00;
    bit   prev_pulse = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frx_packet_rx #(.CLK_FREQ_HZ(CLK_HZ), .BAUD_RATE(BAUD)) i_frx_packet_rx (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in),
        .frame_valid(frame_valid), .frame_flag(frame_flag),
        .frame_param(frame_param), .frame_error(frame_error));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per output pulse and compares.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_pulse)
                check(!frame_valid && !frame_error, "R3", "pulse width",
                      {30'd0, frame_valid, frame_error}, 0);
            prev_pulse = frame_valid || frame_error;
            if (frame_valid || frame_error) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected pulse",
                          {30'd0, frame_valid, frame_error}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(frame_error == e.is_err && frame_valid == !e.is_err,
                          e.req, "pulse kind", {30'd0, frame_valid, frame_error},
                          e.is_err ? 1 : 2);
                    if (!e.is_err) begin
                        check(frame_flag == e.flag, e.req, "kind", frame_flag, e.flag);
                        check(frame_param == e.param, e.req, "argument", frame_param, e.param);
                        last_flag  = e.flag;
                        last_param = e.param;
                    end else begin
                        // R3: outputs held through an error pulse
                        check(frame_flag == last_flag && frame_param == last_param,
                              "R3", "held outputs", {frame_flag, frame_param},
                              {last_flag, last_param});
                    end
                end
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stop_ok = 1'b1);
        serial_in = 1'b0; hold(CPB);
        for (int i = 0; i < 8; i++) begin
            serial_in = b[i]; hold(CPB);
        end
        serial_in = stop_ok; hold(CPB);
        serial_in = 1'b1; hold(2 * CPB);
    endtask

    task automatic push_frame(input logic [7:0] f, input logic [7:0] p, input string req);
        exp_t e;
        e.is_err = 1'b0; e.flag = f; e.param = p; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_err(input string req);
        exp_t e;
        e.is_err = 1'b1; e.flag = 8'h00; e.param = 8'h00; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic settle(input string req);
        hold(3 * CPB);
        check(exp_q.size() == 0, req, "missing pulses", exp_q.size(), 0);
    endtask

    initial begin
        hold(5);
        // R1: reset state
        check(frame_valid == 1'b0, "R1", "frame_valid", frame_valid, 0);
        check(frame_error == 1'b0, "R1", "frame_error", frame_error, 0);
        check(frame_flag == 8'h00, "R1", "frame_flag", frame_flag, 0);
        check(frame_param == 8'h00, "R1", "frame_param", frame_param, 0);
        rst_n = 1'b1;
        hold(2 * CPB);

        // R10: non-header bytes ignored while searching
        send_byte(8'h00); send_byte(8'h55); send_byte(8'h01); send_byte(8'hB2);
        settle("R10");

        // R2: basic frame, asymmetric argument checks bit order
        push_frame(8'h01, 8'hB2, "R2");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h01); send_byte(8'hB2);
        settle("R2");

        // R4: report kind accepted
        push_frame(8'h88, 8'h1D, "R4");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h88); send_byte(8'h1D);
        settle("R4");

        // R5: bad second header byte, following bytes not a kind
        push_err("R5");
        send_byte(8'h7E); send_byte(8'h42); send_byte(8'h01); send_byte(8'h55);
        settle("R5");

        // R6: unknown kind, and 0x7E in the kind position
        push_err("R6");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h02);
        push_err("R6");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h7E);
        push_frame(8'h01, 8'h5A, "R6");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h01); send_byte(8'h5A);
        settle("R6");

        // R7: 0x7E as argument
        push_frame(8'h88, 8'h7E, "R7");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h88); send_byte(8'h7E);
        settle("R7");

        // R8: bad stop bit discards the byte without moving the parser
        push_frame(8'h01, 8'hC3, "R8");
        send_byte(8'h7E); send_byte(8'h7E, 1'b0);
        send_byte(8'h7E); send_byte(8'h01); send_byte(8'hC3);
        settle("R8");

        // R9: short glitch does not start a character
        serial_in = 1'b0; hold(3); serial_in = 1'b1; hold(2 * CPB);
        settle("R9");
        push_frame(8'h88, 8'h11, "R9");
        send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h88); send_byte(8'h11);
        settle("R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule